// File: doc/BRIEF.md
# I2C Interrupt Grouping Logic

This block sits beside the byte engine of an I2C master and turns its raw event pulses into a set of sticky status flags and a single level interrupt. The flags fall into three classes: bus events (start condition sent, address phase done, byte finished), buffer conditions (receive data waiting, transmit holding register empty) and faults (acknowledge missing, arbitration lost, bus error). A control register holds one enable bit per class. The interrupt line is high while any flag in an enabled class is set.

Each class has its own way of clearing. Fault flags are cleared by software writing a zero to their bit in the first status register. The address flag clears after a read of the first status register followed by a read of the second. The start, byte-finished and buffer flags clear as a side effect of data-register traffic. Because the buffer class has its own enable, software can silence per-byte interrupts and still be woken by byte-finished events.

Top module: `i2c_irq_group`

## Requirements
- R1: After reset the control register, the first status register and the interrupt output are all zero.
- R2: The control register is written when reg_sel is 0. Only bit 8 (fault enable), bit 9 (event enable) and bit 10 (buffer enable) are stored. All other control bits read back as 0.
- R3: A pulse on a set input makes its flag read 1 in status register one on the next cycle. The bit positions are start=0, address=1, byte-finished=2, receive-waiting=6, transmit-empty=7, bus error=8, arbitration lost=9 and ack missing=10. The set inputs are evt_set_i[0..2] for start, address and byte-finished; buf_set_i[0] for receive-waiting and buf_set_i[1] for transmit-empty; err_set_i[0..2] for bus error, arbitration lost and ack missing.
- R4: irq_o is the OR over the three classes of (class enable AND any flag of that class). It is a level that holds while such a flag is set.
- R5: With buffer enable off and event enable on, a set transmit-empty flag does not hold irq_o high, but a set byte-finished flag does.
- R6: A write to status register one (reg_sel 1) clears each fault flag whose written bit is 0. A flag whose written bit is 1 keeps its value.
- R7: A set pulse in the same cycle as the clear of its own flag leaves that flag set. This holds for a fault flag under a write-0 and for the address flag under the status-two read.
- R8: The address flag clears on a read of status register two (reg_sel 2) only after a read of status register one that saw the flag set. A status-two read alone leaves the flag set.
- R9: Transmit-empty clears on a data-register write and receive-waiting clears on a data-register read. Writes to status register one leave both unchanged.
- R10: The start flag clears on a data-register write and is unaffected by a data-register read. The byte-finished flag clears on either a data-register read or a data-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_set_i | input | 3 | Event-class set pulses: start, address, byte-finished |
| buf_set_i | input | 2 | Buffer-class set pulses: receive-waiting, transmit-empty |
| err_set_i | input | 3 | Fault-class set pulses: bus error, arbitration lost, ack missing |
| dr_wr_i | input | 1 | Data register write strobe |
| dr_rd_i | input | 1 | Data register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 status one, 2 status two |
| reg_wdata_i | input | 16 | Register write data |
| ctrl_o | output | 16 | Control register contents |
| stat1_o | output | 16 | Status register one contents |
| irq_o | output | 1 | Level interrupt |

## Verification
Every flag and the control register change at the first clock edge after the strobe that moves them. irq_o is decoded without a register from those flags, so it is valid in the same cycle as the flag. The bench drives each strobe for one cycle starting at a falling edge. It samples at the following falling edge, after the single register stage has updated and before the next stimulus is applied. This is repeated for all eight enable patterns against every flag. The sweep also checks each clearing path, each stimulus that must not clear a flag, and the same-cycle set-versus-clear cases.

// File: rtl/i2c_irq_group_pkg.sv
package i2c_irq_group_pkg;
    localparam int REG_W   = 16;
    localparam int SEL_W   = 2;
    localparam int N_EVT   = 3;
    localparam int N_BUF   = 2;
    localparam int N_ERR   = 3;

    localparam int EN_ERR_BIT = 8;
    localparam int EN_EVT_BIT = 9;
    localparam int EN_BUF_BIT = 10;

    localparam int ST_EVT_LSB = 0;
    localparam int ST_BUF_LSB = 6;
    localparam int ST_ERR_LSB = 8;

    localparam int EVT_START = 0;
    localparam int EVT_ADDR  = 1;
    localparam int EVT_BTF   = 2;
    localparam int BUF_RX    = 0;
    localparam int BUF_TX    = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT1 = 2'd1,
        SEL_STAT2 = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/i2c_irq_err_flags.sv
module i2c_irq_err_flags #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } err_st_t;

    err_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (wr_i && !wdata_i[i]) st_d.flag[i] = 1'b0;
            if (set_i[i])            st_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_err_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(flag_o[g]) |-> $past(wr_i && !wdata_i[g]));
        assert_err_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[g] |=> flag_o[g]);
    end
endmodule

// File: rtl/i2c_irq_evt_flags.sv
module i2c_irq_evt_flags
    import i2c_irq_group_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EVT-1:0] set_i,
    input  logic             dr_wr_i,
    input  logic             dr_rd_i,
    input  logic             st1_rd_i,
    input  logic             st2_rd_i,
    output logic [N_EVT-1:0] flag_o
);
    typedef struct packed {
        logic [N_EVT-1:0] flag;
        logic             armed;
    } evt_st_t;

    evt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dr_wr_i) st_d.flag[EVT_START] = 1'b0;
        if (dr_wr_i || dr_rd_i) st_d.flag[EVT_BTF] = 1'b0;
        if (st1_rd_i && st_q.flag[EVT_ADDR]) st_d.armed = 1'b1;
        if (st2_rd_i && st_q.armed) begin
            st_d.flag[EVT_ADDR] = 1'b0;
            st_d.armed          = 1'b0;
        end
        for (int i = 0; i < N_EVT; i++) begin
            if (set_i[i]) st_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    assert_addr_seq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag_o[EVT_ADDR]) |-> $past(st2_rd_i));
    assert_start_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag_o[EVT_START]) |-> $past(dr_wr_i));
    assert_evt_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[EVT_ADDR] |=> flag_o[EVT_ADDR]);
endmodule

// File: rtl/i2c_irq_buf_flags.sv
module i2c_irq_buf_flags
    import i2c_irq_group_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_BUF-1:0] set_i,
    input  logic             dr_wr_i,
    input  logic             dr_rd_i,
    output logic [N_BUF-1:0] flag_o
);
    typedef struct packed {
        logic [N_BUF-1:0] flag;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dr_rd_i) st_d.flag[BUF_RX] = 1'b0;
        if (dr_wr_i) st_d.flag[BUF_TX] = 1'b0;
        for (int i = 0; i < N_BUF; i++) begin
            if (set_i[i]) st_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    assert_rx_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag_o[BUF_RX]) |-> $past(dr_rd_i));
    assert_tx_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag_o[BUF_TX]) |-> $past(dr_wr_i));
endmodule

// File: rtl/i2c_irq_group.sv
module i2c_irq_group
    import i2c_irq_group_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EVT-1:0] evt_set_i,
    input  logic [N_BUF-1:0] buf_set_i,
    input  logic [N_ERR-1:0] err_set_i,
    input  logic             dr_wr_i,
    input  logic             dr_rd_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [SEL_W-1:0] reg_sel_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] stat1_o,
    output logic             irq_o
);
    typedef struct packed {
        logic en_err;
        logic en_evt;
        logic en_buf;
    } ctrl_st_t;

    ctrl_st_t ctl_d, ctl_q;

    logic [N_EVT-1:0] evt_flag;
    logic [N_BUF-1:0] buf_flag;
    logic [N_ERR-1:0] err_flag;

    logic ctl_wr, st1_wr, st1_rd, st2_rd;
    assign ctl_wr = reg_wr_i && (reg_sel_i == SEL_CTRL);
    assign st1_wr = reg_wr_i && (reg_sel_i == SEL_STAT1);
    assign st1_rd = reg_rd_i && (reg_sel_i == SEL_STAT1);
    assign st2_rd = reg_rd_i && (reg_sel_i == SEL_STAT2);

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d.en_err = reg_wdata_i[EN_ERR_BIT];
            ctl_d.en_evt = reg_wdata_i[EN_EVT_BIT];
            ctl_d.en_buf = reg_wdata_i[EN_BUF_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    i2c_irq_evt_flags u_evt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (evt_set_i),
        .dr_wr_i  (dr_wr_i),
        .dr_rd_i  (dr_rd_i),
        .st1_rd_i (st1_rd),
        .st2_rd_i (st2_rd),
        .flag_o   (evt_flag)
    );

    i2c_irq_buf_flags u_buf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (buf_set_i),
        .dr_wr_i (dr_wr_i),
        .dr_rd_i (dr_rd_i),
        .flag_o  (buf_flag)
    );

    i2c_irq_err_flags #(.N(N_ERR)) u_err (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (err_set_i),
        .wr_i    (st1_wr),
        .wdata_i (reg_wdata_i[ST_ERR_LSB +: N_ERR]),
        .flag_o  (err_flag)
    );

    always_comb begin
        ctrl_o             = '0;
        ctrl_o[EN_ERR_BIT] = ctl_q.en_err;
        ctrl_o[EN_EVT_BIT] = ctl_q.en_evt;
        ctrl_o[EN_BUF_BIT] = ctl_q.en_buf;
        stat1_o                        = '0;
        stat1_o[ST_EVT_LSB +: N_EVT]   = evt_flag;
        stat1_o[ST_BUF_LSB +: N_BUF]   = buf_flag;
        stat1_o[ST_ERR_LSB +: N_ERR]   = err_flag;
    end

    assign irq_o = (ctl_q.en_evt && (|evt_flag))
                || (ctl_q.en_buf && (|buf_flag))
                || (ctl_q.en_err && (|err_flag));

    assert_irq_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ($countones(ctrl_o) != 0));
    assert_buf_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_o[EN_BUF_BIT] && !ctrl_o[EN_ERR_BIT] && !ctrl_o[EN_EVT_BIT]) |-> !irq_o);
    assert_ctrl_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(ctl_wr) |-> $stable(ctrl_o));
endmodule

// File: tb/i2c_irq_group_tb_top.sv
module i2c_irq_group_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt_set = '0;
    logic [1:0]  buf_set = '0;
    logic [2:0]  err_set = '0;
    logic        dr_wr = 1'b0, dr_rd = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] ctrl, stat1;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_irq_group dut_i (
        .clk_i(clk), .rst_ni(rst_n), .evt_set_i(evt_set), .buf_set_i(buf_set),
        .err_set_i(err_set), .dr_wr_i(dr_wr), .dr_rd_i(dr_rd), .reg_wr_i(reg_wr),
        .reg_rd_i(reg_rd), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .ctrl_o(ctrl), .stat1_o(stat1), .irq_o(irq)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        evt_set = '0; buf_set = '0; err_set = '0;
        dr_wr = 0; dr_rd = 0; reg_wr = 0; reg_rd = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic set_flag(int f);
        if (f < 3)      evt_set[f] = 1'b1;
        else if (f < 5) buf_set[f-3] = 1'b1;
        else            err_set[f-5] = 1'b1;
    endtask

    task automatic pulse(int f);
        set_flag(f);
        step();
    endtask

    task automatic wr_reg(logic [1:0] s, logic [15:0] d);
        reg_wr = 1; reg_sel = s; reg_wdata = d;
        step();
    endtask

    task automatic rd_reg(logic [1:0] s);
        reg_rd = 1; reg_sel = s;
        step();
    endtask

    task automatic do_drw(); dr_wr = 1; step(); endtask
    task automatic do_drr(); dr_rd = 1; step(); endtask

    function automatic int pos_of(int f);
        if (f < 3) return f;
        if (f < 5) return f + 3;
        return f + 3;
    endfunction

    function automatic int cls_en_bit(int f);
        if (f < 3) return 9;
        if (f < 5) return 10;
        return 8;
    endfunction

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk("R1 ctrl", ctrl, 16'h0);
        chk("R1 stat1", stat1, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int en = 0; en < 8; en++) begin
            wr_reg(2'd0, 16'h00FF | 16'(en << 8) | 16'hF800);
            chk("R2 ctrl", ctrl, 16'(en << 8));
            for (int f = 0; f < 8; f++) begin
                logic [15:0] bitv;
                logic exp_irq;
                bitv = 16'(1 << pos_of(f));
                exp_irq = ((16'(en << 8)) >> cls_en_bit(f)) & 1;
                pulse(f);
                chk("R3 flag set", stat1, bitv);
                chk("R4 irq level", {15'd0, irq}, {15'd0, exp_irq});
                case (f)
                    0: begin
                        do_drr();
                        chk("R10 start kept on dr read", stat1, bitv);
                        do_drw();
                    end
                    1: begin
                        rd_reg(2'd2);
                        chk("R8 addr kept on lone stat2 read", stat1, bitv);
                        rd_reg(2'd1);
                        rd_reg(2'd2);
                    end
                    2: if (en[0]) do_drw(); else do_drr();
                    3: begin
                        wr_reg(2'd1, 16'h0000);
                        chk("R9 rx kept on stat1 write", stat1, bitv);
                        do_drr();
                    end
                    4: begin
                        wr_reg(2'd1, 16'h0000);
                        chk("R9 tx kept on stat1 write", stat1, bitv);
                        do_drw();
                    end
                    default: begin
                        wr_reg(2'd1, 16'hFFFF);
                        chk("R6 err kept on write 1", stat1, bitv);
                        wr_reg(2'd1, ~bitv);
                    end
                endcase
                chk("R6 R8 R9 R10 flag cleared", stat1, 16'h0);
                chk("R4 irq low after clear", {15'd0, irq}, 16'h0);
            end
        end

        // R7: same-cycle fault set and write-0 clear
        wr_reg(2'd0, 16'h0100);
        pulse(7);
        err_set[2] = 1'b1; reg_wr = 1; reg_sel = 2'd1; reg_wdata = 16'h0000;
        step();
        chk("R7 fault set wins", stat1, 16'h0400);
        wr_reg(2'd1, 16'h0000);
        chk("R7 fault cleared later", stat1, 16'h0000);

        // R7: address set in the same cycle as the clearing status-two read
        pulse(1);
        rd_reg(2'd1);
        evt_set[1] = 1'b1; reg_rd = 1; reg_sel = 2'd2;
        step();
        chk("R7 addr set wins", stat1, 16'h0002);
        rd_reg(2'd1);
        rd_reg(2'd2);
        chk("R8 addr cleared", stat1, 16'h0000);

        // R5: buffer masked, event enabled
        wr_reg(2'd0, 16'h0200);
        pulse(4);
        chk("R5 tx alone no irq", {15'd0, irq}, 16'h0);
        pulse(2);
        chk("R5 btf raises irq", {15'd0, irq}, 16'h1);
        do_drr();
        chk("R5 irq drops with tx still set", {15'd0, irq}, 16'h0);
        chk("R5 tx still set", stat1, 16'h0080);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule